// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer

This block is a register-mapped timer with a parameterised number of independent channels. Each channel holds a control word, a running count and a fixed (reload) count. A channel counts down by one on each qualifying tick and flags an expiry when its count passes from one to zero. It can serve as a free-running time base: reload is on, the fixed count is all ones, and software reads the running count and inverts it to get a rising time value. It can also serve as a one-shot event timer, where update is on and each write of the fixed count starts a new countdown.

A four-bit tick select field picks the tick source. One code counts on every clock. Another counts only on cycles where the external slow tick enable is high. Every other code holds the count. Control words and the global control word have set and clear alias addresses, so single bits can change without a read-modify-write. A read-only version word reports the counter variant. Writes take effect on the clock edge, and read data is combinational from the address.

Top module: `mc_timer_top`

## Requirements
- R1: Synchronous active-high reset clears every control word, running count, fixed count, the global control word and all interrupt outputs.
- R2: Channel n maps its control word at 0x20+n*0x40, running count at 0x30+n*0x40 and fixed count at 0x40+n*0x40. The fixed count reads back what was written. Writes to the running count are ignored. Control bits other than 3:0, 6, 7, 14 and 15 read as zero.
- R3: Control bits 3:0 select the tick. 0xF counts every clock, 0xB counts only on cycles with slow_tick high, and any other code holds the running count.
- R4: Each tick decrements a non-zero running count by one. A tick that takes the count from 1 to 0 is an expiry and sets the flag in control bit 15.
- R5: With control bit 6 (reload) set, an expiry loads the running count from the fixed count instead of zero. A tick that finds the count at zero loads the fixed count without raising the flag.
- R6: With reload clear, the channel stops at zero after an expiry, flags once, and produces no further expiries until the count is reloaded.
- R7: With control bit 7 (update) set, a fixed-count write also loads the running count. With it clear, the running count is left unchanged.
- R8: Writing a mask to the control offset +0x4 ORs it into the word, and writing to +0x8 clears those bits. Reads at either alias return the control word.
- R9: Channel interrupt output irq[n] is high exactly when the flag (bit 15) and the enable (bit 14) are both set.
- R10: If a clear of the flag and a new expiry fall in the same cycle, the flag ends set.
- R11: Offset 0x3FC reads 0x02000000: major version 2 in bits 31:24, all other bits zero. Writes there are ignored.
- R12: The global control word sits at 0x00 with set/clear aliases at 0x04/0x08. Its bit 0 halts counting in every channel while set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | AW | Byte offset of the register |
| bus_wdata | input | 32 | Write data or bit mask |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| slow_tick | input | 1 | Slow external tick enable |
| irq | output | NCH | Per-channel interrupt outputs |

## Verification
The bench drives the slow tick one pulse at a time, so it knows the exact tick on which a count passes from one to zero. It checks that the flag rises on that tick and not one tick early or late, the error a design that expires on reaching zero would make. It clears the flag in the very cycle of an expiry, where a design with the wrong priority would lose the event. It lets a non-reloading channel sit at zero through extra ticks, where a design would otherwise re-flag or wrap to all ones. It also writes a fixed count with update off, and writes the read-only running count, where a design could corrupt a live countdown.

// File: rtl/timer_pkg.sv
package timer_pkg;

    localparam int REG_W = 32;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_WR   = 2'd1,
        OP_SET  = 2'd2,
        OP_CLR  = 2'd3
    } op_e;

    // control word fields
    localparam int B_RELOAD = 6;
    localparam int B_UPDATE = 7;
    localparam int B_IEN    = 14;
    localparam int B_FLAG   = 15;
    localparam logic [3:0] SEL_ALWAYS = 4'hF;
    localparam logic [3:0] SEL_SLOW   = 4'hB;

    localparam logic [REG_W-1:0] CTRL_MASK    = 32'h0000_C0CF;
    localparam logic [REG_W-1:0] FLAG_BIT     = 32'h0000_8000;
    localparam logic [REG_W-1:0] GLOB_MASK    = 32'h0000_0001;
    localparam logic [REG_W-1:0] VERSION_WORD = {8'd2, 24'd0};

    localparam int unsigned SET_OFF = 32'h4;
    localparam int unsigned CLR_OFF = 32'h8;

    function automatic int unsigned ctrl_off(input int unsigned n);
        return 32'h20 + n * 32'h40;
    endfunction

    function automatic int unsigned run_off(input int unsigned n);
        return 32'h30 + n * 32'h40;
    endfunction

    function automatic int unsigned fix_off(input int unsigned n);
        return 32'h40 + n * 32'h40;
    endfunction

    function automatic logic [REG_W-1:0] apply_op(
        input logic [REG_W-1:0] cur,
        input op_e              op,
        input logic [REG_W-1:0] wd,
        input logic [REG_W-1:0] mask
    );
        logic [REG_W-1:0] r;
        case (op)
            OP_WR:   r = wd;
            OP_SET:  r = cur | wd;
            OP_CLR:  r = cur & ~wd;
            default: r = cur;
        endcase
        return r & mask;
    endfunction

endpackage

// File: rtl/tmr_regdec.sv
module tmr_regdec
    import timer_pkg::*;
#(
    parameter int NCH = 2,
    parameter int AW  = 10
) (
    input  logic            we,
    input  logic [AW-1:0]   addr,
    output op_e [NCH-1:0]   ctrl_op,
    output logic [NCH-1:0]  fix_we,
    output op_e             glob_op
);
    logic [31:0] a;

    always_comb begin
        a       = 32'(addr);
        glob_op = OP_NONE;
        ctrl_op = '{default: OP_NONE};
        fix_we  = '0;
        if (we) begin
            if (a == 32'h0)          glob_op = OP_WR;
            else if (a == SET_OFF)   glob_op = OP_SET;
            else if (a == CLR_OFF)   glob_op = OP_CLR;
            for (int n = 0; n < NCH; n++) begin
                if (a == ctrl_off(n))                ctrl_op[n] = OP_WR;
                else if (a == ctrl_off(n) + SET_OFF) ctrl_op[n] = OP_SET;
                else if (a == ctrl_off(n) + CLR_OFF) ctrl_op[n] = OP_CLR;
                if (a == fix_off(n)) fix_we[n] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  op_e               ctrl_op,
    input  logic              fix_we,
    input  logic [REG_W-1:0]  wdata,
    input  logic              slow_tick,
    input  logic              halt,
    output logic [REG_W-1:0]  ctrl_q,
    output logic [CNT_W-1:0]  run_q,
    output logic [CNT_W-1:0]  fix_q,
    output logic              irq
);
    logic tick_en;
    logic load;
    logic expire;

    always_comb begin
        tick_en = !halt && ((ctrl_q[3:0] == SEL_ALWAYS) ||
                            (ctrl_q[3:0] == SEL_SLOW && slow_tick));
        load    = fix_we && ctrl_q[B_UPDATE];
        expire  = tick_en && !load && (run_q == CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            run_q  <= '0;
            fix_q  <= '0;
        end else begin
            // a new expiry overrides a same-cycle clear of the flag
            ctrl_q <= apply_op(ctrl_q, ctrl_op, wdata, CTRL_MASK) |
                      (expire ? FLAG_BIT : '0);
            if (fix_we) fix_q <= wdata[CNT_W-1:0];
            if (load) begin
                run_q <= wdata[CNT_W-1:0];
            end else if (tick_en) begin
                if (run_q == CNT_W'(1))  run_q <= ctrl_q[B_RELOAD] ? fix_q : '0;
                else if (run_q != '0)    run_q <= run_q - CNT_W'(1);
                else if (ctrl_q[B_RELOAD]) run_q <= fix_q;
            end
        end
    end

    assign irq = ctrl_q[B_FLAG] & ctrl_q[B_IEN];

    // R3
    hold_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !fix_we) |=> $stable(run_q));

    // R4 R10
    expiry_flag_chk: assert property (@(posedge clk) disable iff (rst)
        expire |=> ctrl_q[B_FLAG]);

    // R5
    reload_value_chk: assert property (@(posedge clk) disable iff (rst)
        (expire && ctrl_q[B_RELOAD]) |=> (run_q == $past(fix_q)));

    // R6
    stop_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (run_q == '0 && !ctrl_q[B_RELOAD] && !fix_we) |=> (run_q == '0));

    // R7
    update_load_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (run_q == $past(wdata[CNT_W-1:0])));
endmodule

// File: rtl/mc_timer_top.sv
module mc_timer_top
    import timer_pkg::*;
#(
    parameter int NCH     = 2,
    parameter int AW      = 10,
    parameter int CNT_W   = 32,
    parameter int VER_OFF = 'h3FC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic             slow_tick,
    output logic [NCH-1:0]   irq
);
    op_e [NCH-1:0]     ctrl_op;
    logic [NCH-1:0]    fix_we;
    op_e               glob_op;
    logic [REG_W-1:0]  glob_q;
    logic [REG_W-1:0]  ctrl_q [NCH];
    logic [CNT_W-1:0]  run_q  [NCH];
    logic [CNT_W-1:0]  fix_q  [NCH];

    tmr_regdec #(.NCH(NCH), .AW(AW)) dec_i (
        .we      (bus_we),
        .addr    (bus_addr),
        .ctrl_op (ctrl_op),
        .fix_we  (fix_we),
        .glob_op (glob_op)
    );

    always_ff @(posedge clk) begin
        if (rst) glob_q <= '0;
        else     glob_q <= apply_op(glob_q, glob_op, bus_wdata, GLOB_MASK);
    end

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        tmr_channel #(.CNT_W(CNT_W)) ch_i (
            .clk       (clk),
            .rst       (rst),
            .ctrl_op   (ctrl_op[n]),
            .fix_we    (fix_we[n]),
            .wdata     (bus_wdata),
            .slow_tick (slow_tick),
            .halt      (glob_q[0]),
            .ctrl_q    (ctrl_q[n]),
            .run_q     (run_q[n]),
            .fix_q     (fix_q[n]),
            .irq       (irq[n])
        );

        // R9
        irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
            !ctrl_q[n][B_IEN] |-> !irq[n]);
    end

    always_comb begin
        logic [31:0] a;
        a         = 32'(bus_addr);
        bus_rdata = '0;
        if (a == 32'h0 || a == SET_OFF || a == CLR_OFF) bus_rdata = glob_q;
        if (a == 32'(VER_OFF)) bus_rdata = VERSION_WORD;
        for (int n = 0; n < NCH; n++) begin
            if (a == ctrl_off(n) || a == ctrl_off(n) + SET_OFF ||
                a == ctrl_off(n) + CLR_OFF)
                bus_rdata = ctrl_q[n];
            if (a == run_off(n)) bus_rdata = REG_W'(run_q[n]);
            if (a == fix_off(n)) bus_rdata = REG_W'(fix_q[n]);
        end
    end

    // R11
    version_read_chk: assert property (@(posedge clk) disable iff (rst)
        (32'(bus_addr) == 32'(VER_OFF)) |-> (bus_rdata[31:24] == 8'd2));

    // R12
    halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (glob_q[0] && !fix_we[0]) |=> $stable(run_q[0]));
endmodule

// File: tb/mc_timer_top_tb.sv
module mc_timer_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 10;
    localparam int NCH        = 2;
    localparam int TIMEOUT    = 20000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             bus_we = 1'b0;
    logic [AW-1:0]    bus_addr = '0;
    logic [31:0]      bus_wdata = '0;
    logic [31:0]      bus_rdata;
    logic             slow_tick = 1'b0;
    logic [NCH-1:0]   irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mc_timer_top #(.NCH(NCH), .AW(AW)) dut_i (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .slow_tick(slow_tick), .irq(irq)
    );

    // {write, addr, data, expected, requirement number}
    localparam int NV = 28;
    localparam logic [84:0] VEC [NV] = '{
        {1'b0, 16'h0020, 32'h0, 32'h0, 4'd1},          // R1
        {1'b0, 16'h0030, 32'h0, 32'h0, 4'd1},          // R1
        {1'b0, 16'h0040, 32'h0, 32'h0, 4'd1},          // R1
        {1'b0, 16'h0000, 32'h0, 32'h0, 4'd1},          // R1
        {1'b0, 16'h0060, 32'h0, 32'h0, 4'd1},          // R1
        {1'b1, 16'h0040, 32'h1234, 32'h0, 4'd2},       // R2
        {1'b0, 16'h0040, 32'h0, 32'h1234, 4'd2},       // R2
        {1'b0, 16'h0030, 32'h0, 32'h0, 4'd7},          // R7
        {1'b1, 16'h0030, 32'hDEAD, 32'h0, 4'd2},       // R2
        {1'b0, 16'h0030, 32'h0, 32'h0, 4'd2},          // R2
        {1'b1, 16'h0020, 32'h4040, 32'h0, 4'd8},       // R8
        {1'b0, 16'h0020, 32'h0, 32'h4040, 4'd8},       // R8
        {1'b1, 16'h0024, 32'h0080, 32'h0, 4'd8},       // R8
        {1'b0, 16'h0020, 32'h0, 32'h40C0, 4'd8},       // R8
        {1'b0, 16'h0024, 32'h0, 32'h40C0, 4'd8},       // R8
        {1'b1, 16'h0028, 32'h4000, 32'h0, 4'd8},       // R8
        {1'b0, 16'h0028, 32'h0, 32'h00C0, 4'd8},       // R8
        {1'b1, 16'h0020, 32'hFFFF3F30, 32'h0, 4'd2},   // R2
        {1'b0, 16'h0020, 32'h0, 32'h0, 4'd2},          // R2
        {1'b0, 16'h03FC, 32'h0, 32'h02000000, 4'd11},  // R11
        {1'b1, 16'h03FC, 32'h0, 32'h0, 4'd11},         // R11
        {1'b0, 16'h03FC, 32'h0, 32'h02000000, 4'd11},  // R11
        {1'b1, 16'h0004, 32'h1, 32'h0, 4'd12},         // R12
        {1'b0, 16'h0000, 32'h0, 32'h1, 4'd12},         // R12
        {1'b1, 16'h0008, 32'h1, 32'h0, 4'd12},         // R12
        {1'b0, 16'h0000, 32'h0, 32'h0, 4'd12},         // R12
        {1'b1, 16'h0080, 32'h55, 32'h0, 4'd2},         // R2
        {1'b0, 16'h0080, 32'h0, 32'h55, 4'd2}          // R2
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rchk(input string req, input logic [15:0] a, input logic [31:0] exp);
        bus_addr = AW'(a);
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            slow_tick = 1'b1;
            @(negedge clk);
            slow_tick = 1'b0;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (TIMEOUT) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 irq", 32'(irq), 32'h0);

        for (int v = 0; v < NV; v++) begin
            if (VEC[v][84]) wr(VEC[v][83:68], VEC[v][67:36]);
            else rchk($sformatf("R%0d vec%0d", VEC[v][3:0], v), VEC[v][83:68], VEC[v][35:4]);
        end

        // channel 0: slow tick, update on, one-shot
        wr(16'h0020, 32'h008B);
        wr(16'h0040, 32'd3);
        rchk("R7 update load", 16'h0030, 32'd3);
        tick(1);
        rchk("R4 decrement", 16'h0030, 32'd2);
        repeat (3) @(negedge clk);
        rchk("R3 slow gate hold", 16'h0030, 32'd2);
        tick(2);
        rchk("R4 count zero", 16'h0030, 32'd0);
        rchk("R4 flag on expiry", 16'h0020, 32'h808B);
        chk("R9 irq masked", 32'(irq[0]), 32'h0);
        tick(2);
        rchk("R6 stop at zero", 16'h0030, 32'd0);
        wr(16'h0028, 32'h8000);
        tick(2);
        rchk("R6 single flag", 16'h0020, 32'h008B);

        // interrupt gating
        wr(16'h0024, 32'h4000);
        wr(16'h0040, 32'd1);
        chk("R9 irq idle", 32'(irq[0]), 32'h0);
        tick(1);
        chk("R9 irq raised", 32'(irq[0]), 32'h1);
        wr(16'h0028, 32'h8000);
        chk("R9 irq cleared", 32'(irq[0]), 32'h0);

        // reload on expiry
        wr(16'h0024, 32'h0040);
        wr(16'h0040, 32'd2);
        tick(1);
        rchk("R5 pre-expiry", 16'h0030, 32'd1);
        tick(1);
        rchk("R5 reload value", 16'h0030, 32'd2);
        rchk("R5 reload flag", 16'h0020, 32'hC0CB);
        wr(16'h0028, 32'h8000);

        // fixed write without update, reload from zero
        wr(16'h0028, 32'h00C0);
        tick(2);
        wr(16'h0028, 32'h8000);
        wr(16'h0040, 32'd5);
        rchk("R7 no update", 16'h0030, 32'd0);
        rchk("R7 fixed stored", 16'h0040, 32'd5);
        wr(16'h0024, 32'h0040);
        tick(1);
        rchk("R5 reload from zero", 16'h0030, 32'd5);
        rchk("R5 no flag from zero", 16'h0020, 32'h404B);

        // clear and expiry in the same cycle
        tick(4);
        wr(16'h0024, 32'h8000);
        bus_we = 1'b1; bus_addr = AW'(16'h0028); bus_wdata = 32'h8000; slow_tick = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; slow_tick = 1'b0;
        rchk("R10 expiry wins", 16'h0020, 32'hC04B);
        rchk("R10 reloaded", 16'h0030, 32'd5);

        // global halt
        wr(16'h0004, 32'h1);
        tick(3);
        rchk("R12 halted", 16'h0030, 32'd5);
        wr(16'h0008, 32'h1);
        tick(1);
        rchk("R12 resumed", 16'h0030, 32'd4);

        // channel 1 free-running on every clock
        wr(16'h0060, 32'h0080);
        wr(16'h0080, 32'hFFFF_FFFF);
        wr(16'h0064, 32'h000F);
        repeat (10) @(negedge clk);
        bus_addr = AW'(16'h0070); #1;
        chk("R3 every clock", ~bus_rdata, 32'd10);
        wr(16'h0068, 32'h000F);
        repeat (5) @(negedge clk);
        bus_addr = AW'(16'h0070); #1;
        chk("R3 other code holds", ~bus_rdata, 32'd11);

        // reset mid-run
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        rchk("R1 ctrl after reset", 16'h0020, 32'h0);
        rchk("R1 run after reset", 16'h0070, 32'h0);
        rchk("R1 fixed after reset", 16'h0040, 32'h0);
        chk("R1 irq after reset", 32'(irq), 32'h0);

        finish_run();
    end
endmodule